// File: doc/BRIEF.md
# Variable Audio Delay Line

The block delays a stream of audio samples by a chosen number of sample periods. Each sample strobe (nominally 44.1 kHz, far slower than the system clock) starts one access sequence on a single-port SRAM that acts as a circular buffer. The sequence first reads the delayed sample and then stores the new one. A free-running write pointer addresses the store. A loadable read pointer addresses the fetch. The number of samples by which the write pointer leads the read pointer is the delay. An address mux picks which pointer drives the memory in each cycle.

A delay change is requested with a one-cycle strobe and a requested length. The request is clamped to the legal range and applied between sample periods. It is applied by loading the read pointer with the write pointer minus the new length, modulo the buffer depth. Until enough samples have been stored after reset to cover the current delay, the block outputs zero instead of stale memory.

The sequencer is a state machine with five states:
- `ST_IDLE`: waiting.
- `ST_LOAD`: applying a pending delay change.
- `ST_READ`: memory read at the read pointer.
- `ST_CAPTURE`: registering the output sample.
- `ST_WRITE`: memory write at the write pointer, after which both pointers step.

The transitions are:
- `ST_IDLE` to `ST_READ` when a sample strobe is pending. This has priority.
- `ST_IDLE` to `ST_LOAD` when only a delay request is pending.
- `ST_LOAD` to `ST_IDLE`.
- `ST_READ` to `ST_CAPTURE`.
- `ST_CAPTURE` to `ST_WRITE`.
- `ST_WRITE` to `ST_IDLE`.

Top module: `sample_delay_line`

## Requirements
- R1: After reset `out_sample` is zero and `out_strobe` is low.
- R2: Each accepted sample strobe produces exactly one single-cycle `out_strobe`. Within that sequence the memory read comes before the memory write.
- R3: After reset, with no delay request, the delay is `INIT_DELAY` samples: the k-th output equals the input of strobe k-`INIT_DELAY`.
- R4: After a delay request of D (applied while no strobe is being served), output k equals input k-D, counting strobes since reset.
- R5: A requested delay above DEPTH-1 (DEPTH = 2^`ADDR_W`) is used as DEPTH-1.
- R6: A requested delay of zero is used as one sample.
- R7: While fewer than D samples have been stored since reset, the output of a sequence is zero.
- R8: Both pointers wrap modulo DEPTH, so the delay stays correct over any number of strobes beyond DEPTH.
- R9: A strobe that arrives while a sequence is running is held, one deep, together with its sample, and is served right after the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sample-rate strobe, one cycle wide |
| in_sample | input | DATA_W | Sample taken with `tick` |
| set_delay | input | 1 | One-cycle delay change request |
| delay_req | input | ADDR_W+1 | Requested delay in samples, clamped per R5/R6 |
| out_sample | output | DATA_W | Delayed sample register |
| out_strobe | output | 1 | High for one cycle when `out_sample` updates |

## Verification
The main path is driven in several phases:
- Random samples at the reset delay. The first samples tell the zero-fill rule (R7) apart from stale memory.
- A short delay and a delay of zero, which tell a correct pointer load apart from an off-by-one.
- An oversized request, which only matches the model if clamping works. The run then continues past DEPTH strobes, which exposes wrap errors.
- Back-to-back strobe pairs, which separate a one-deep pending queue from a design that drops or mixes samples.
- A long random phase with random delay changes, checked against a history model in the bench.

// File: rtl/dly_pkg.sv
package dly_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_LOAD    = 3'd1,
        ST_READ    = 3'd2,
        ST_CAPTURE = 3'd3,
        ST_WRITE   = 3'd4
    } dly_state_e;
endpackage

// File: rtl/dly_ctrl.sv
// Sequencer: one read then one write per sample period, delay loads in between.
module dly_ctrl
    import dly_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       set_delay,
    output dly_state_e state,
    output logic       mem_en,
    output logic       mem_we,
    output logic       addr_sel_wr,
    output logic       load_go,
    output logic       advance_go,
    output logic       capture_go,
    output logic       take_sample
);
    dly_state_e state_nx;
    logic       tick_pend;
    logic       load_pend;
    logic       idle_start_rd;
    logic       idle_start_ld;

    assign idle_start_rd = (state == ST_IDLE) && tick_pend;
    assign idle_start_ld = (state == ST_IDLE) && !tick_pend && load_pend;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // pending flags: a new request wins over the clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_pend <= 1'b0;
            load_pend <= 1'b0;
        end else begin
            tick_pend <= tick | (tick_pend & ~idle_start_rd);
            load_pend <= set_delay | (load_pend & ~idle_start_ld);
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (tick_pend) begin
                    state_nx = ST_READ;
                end else if (load_pend) begin
                    state_nx = ST_LOAD;
                end
            end
            ST_LOAD:    state_nx = ST_IDLE;
            ST_READ:    state_nx = ST_CAPTURE;
            ST_CAPTURE: state_nx = ST_WRITE;
            ST_WRITE:   state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_en      = 1'b0;
        mem_we      = 1'b0;
        addr_sel_wr = 1'b0;
        load_go     = 1'b0;
        advance_go  = 1'b0;
        capture_go  = 1'b0;
        take_sample = idle_start_rd;
        unique case (state)
            ST_IDLE:    ;
            ST_LOAD:    load_go = 1'b1;
            ST_READ:    mem_en = 1'b1;
            ST_CAPTURE: capture_go = 1'b1;
            ST_WRITE: begin
                mem_en      = 1'b1;
                mem_we      = 1'b1;
                addr_sel_wr = 1'b1;
                advance_go  = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dly_addr_gen.sv
// Write/read pointers, delay register, fill count and address mux.
module dly_addr_gen #(
    parameter int ADDR_W     = 6,
    parameter int INIT_DELAY = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_delay,
    input  logic [ADDR_W:0]   delay_req,
    input  logic              load_go,
    input  logic              advance_go,
    input  logic              addr_sel_wr,
    output logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] wr_ptr,
    output logic [ADDR_W-1:0] rd_ptr,
    output logic [ADDR_W-1:0] cur_delay,
    output logic [ADDR_W:0]   fill,
    output logic              primed
);
    localparam int                DEPTH   = 1 << ADDR_W;
    localparam int                MAX_D   = DEPTH - 1;
    localparam logic [ADDR_W-1:0] D_INIT  = ADDR_W'(INIT_DELAY);
    localparam logic [ADDR_W-1:0] RD_INIT = ADDR_W'(DEPTH - INIT_DELAY);
    localparam logic [ADDR_W:0]   FULL    = (ADDR_W+1)'(DEPTH);

    logic [ADDR_W-1:0] req_hold;

    function automatic logic [ADDR_W-1:0] clamp_delay(input logic [ADDR_W:0] r);
        if (r == '0) begin
            return ADDR_W'(1);
        end else if (r > (ADDR_W+1)'(MAX_D)) begin
            return ADDR_W'(MAX_D);
        end else begin
            return r[ADDR_W-1:0];
        end
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_hold <= D_INIT;
        end else if (set_delay) begin
            req_hold <= clamp_delay(delay_req);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr    <= '0;
            rd_ptr    <= RD_INIT;
            cur_delay <= D_INIT;
            fill      <= '0;
        end else if (load_go) begin
            rd_ptr    <= wr_ptr - req_hold;
            cur_delay <= req_hold;
        end else if (advance_go) begin
            wr_ptr <= wr_ptr + 1'b1;
            rd_ptr <= rd_ptr + 1'b1;
            if (fill != FULL) begin
                fill <= fill + 1'b1;
            end
        end
    end

    assign primed = (fill >= {1'b0, cur_delay});
    assign addr   = addr_sel_wr ? wr_ptr : rd_ptr;
endmodule

// File: rtl/dly_sram.sv
// Single-port synchronous SRAM, registered read.
module dly_sram #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem[addr] <= wdata;
            end else begin
                rdata <= mem[addr];
            end
        end
    end
endmodule

// File: rtl/sample_delay_line.sv
module sample_delay_line
    import dly_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int ADDR_W     = 6,
    parameter int INIT_DELAY = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [DATA_W-1:0] in_sample,
    input  logic              set_delay,
    input  logic [ADDR_W:0]   delay_req,
    output logic [DATA_W-1:0] out_sample,
    output logic              out_strobe
);
    dly_state_e        state;
    logic              mem_en;
    logic              mem_we;
    logic              addr_sel_wr;
    logic              load_go;
    logic              advance_go;
    logic              capture_go;
    logic              take_sample;
    logic [ADDR_W-1:0] addr;
    logic [ADDR_W-1:0] wr_ptr;
    logic [ADDR_W-1:0] rd_ptr;
    logic [ADDR_W-1:0] cur_delay;
    logic [ADDR_W:0]   fill;
    logic              primed;
    logic [DATA_W-1:0] rdata;
    logic [DATA_W-1:0] in_pend;
    logic [DATA_W-1:0] in_work;

    dly_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .set_delay   (set_delay),
        .state       (state),
        .mem_en      (mem_en),
        .mem_we      (mem_we),
        .addr_sel_wr (addr_sel_wr),
        .load_go     (load_go),
        .advance_go  (advance_go),
        .capture_go  (capture_go),
        .take_sample (take_sample)
    );

    dly_addr_gen #(
        .ADDR_W     (ADDR_W),
        .INIT_DELAY (INIT_DELAY)
    ) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_delay   (set_delay),
        .delay_req   (delay_req),
        .load_go     (load_go),
        .advance_go  (advance_go),
        .addr_sel_wr (addr_sel_wr),
        .addr        (addr),
        .wr_ptr      (wr_ptr),
        .rd_ptr      (rd_ptr),
        .cur_delay   (cur_delay),
        .fill        (fill),
        .primed      (primed)
    );

    dly_sram #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_mem (
        .clk   (clk),
        .en    (mem_en),
        .we    (mem_we),
        .addr  (addr),
        .wdata (in_work),
        .rdata (rdata)
    );

    // input staging: one pending sample plus the one being stored
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_pend <= '0;
            in_work <= '0;
        end else begin
            if (take_sample) begin
                in_work <= in_pend;
            end
            if (tick) begin
                in_pend <= in_sample;
            end
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_sample <= '0;
            out_strobe <= 1'b0;
        end else begin
            out_strobe <= capture_go;
            if (capture_go) begin
                out_sample <= primed ? rdata : '0;
            end
        end
    end
endmodule

// File: rtl/dly_checker.sv
module dly_checker #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              out_strobe,
    input logic [DATA_W-1:0] out_sample,
    input logic              mem_we,
    input logic [ADDR_W-1:0] wr_ptr,
    input logic [ADDR_W-1:0] rd_ptr,
    input logic [ADDR_W-1:0] cur_delay,
    input logic [ADDR_W:0]   fill
);
    localparam logic [ADDR_W:0] FULL = (ADDR_W+1)'(1 << ADDR_W);

    logic [ADDR_W-1:0] gap;
    assign gap = wr_ptr - rd_ptr;

    p_strobe_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_strobe |=> !out_strobe);

    p_read_before_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> out_strobe);

    p_wr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (wr_ptr == ADDR_W'($past(wr_ptr) + 1'b1)));

    p_gap_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (gap == $past(gap)));

    p_zero_unprimed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_strobe && (fill < {1'b0, cur_delay})) |-> (out_sample == '0));

    p_fill_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FULL);

    p_delay_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cur_delay != '0);
endmodule

bind sample_delay_line dly_checker #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_dly_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .out_strobe (out_strobe),
    .out_sample (out_sample),
    .mem_we     (mem_we),
    .wr_ptr     (wr_ptr),
    .rd_ptr     (rd_ptr),
    .cur_delay  (cur_delay),
    .fill       (fill)
);

// File: tb/sample_delay_line_tb_top.sv
module sample_delay_line_tb_top;
    localparam int DW    = 16;
    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;
    localparam int INITD = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic [DW-1:0] in_sample = '0;
    logic          set_delay = 1'b0;
    logic [AW:0]   delay_req = '0;
    logic [DW-1:0] out_sample;
    logic          out_strobe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [DW-1:0] hist [0:1023];
    int n_ticks = 0;
    int cur_d = INITD;

    always #10 clk = ~clk;

    sample_delay_line #(
        .DATA_W     (DW),
        .ADDR_W     (AW),
        .INIT_DELAY (INITD)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .in_sample  (in_sample),
        .set_delay  (set_delay),
        .delay_req  (delay_req),
        .out_sample (out_sample),
        .out_strobe (out_strobe)
    );

    function automatic int model_clamp(input int r);
        if (r == 0) return 1;
        if (r > DEPTH - 1) return DEPTH - 1;
        return r;
    endfunction

    function automatic logic [DW-1:0] model_expect(input int n, input int d);
        if (n >= d) return hist[n - d];
        return '0;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_check(input logic [DW-1:0] exp, input string tag);
        int waited = 0;
        while (!out_strobe && waited < 20) begin
            @(negedge clk);
            waited++;
        end
        if (!out_strobe) begin
            check(1'b0, "R2 strobe missing", '0, 16'h0001);
        end else begin
            check(out_sample == exp, tag, out_sample, exp);
            @(negedge clk);
            check(!out_strobe, "R2 strobe width", {15'd0, out_strobe}, '0);
        end
    endtask

    task automatic send_tick(input logic [DW-1:0] s, input string tag);
        logic [DW-1:0] exp;
        exp = model_expect(n_ticks, cur_d);
        hist[n_ticks] = s;
        n_ticks++;
        @(negedge clk);
        in_sample = s;
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        wait_check(exp, tag);
        repeat (2) @(negedge clk);
    endtask

    task automatic send_pair(input logic [DW-1:0] a, input logic [DW-1:0] b);
        logic [DW-1:0] ea;
        logic [DW-1:0] eb;
        ea = model_expect(n_ticks, cur_d);
        hist[n_ticks] = a;
        n_ticks++;
        eb = model_expect(n_ticks, cur_d);
        hist[n_ticks] = b;
        n_ticks++;
        @(negedge clk);
        in_sample = a;
        tick = 1'b1;
        @(negedge clk);
        in_sample = b;
        @(negedge clk);
        tick = 1'b0;
        wait_check(ea, "R9 first");
        wait_check(eb, "R9 second");
        repeat (2) @(negedge clk);
    endtask

    task automatic request_delay(input int r);
        @(negedge clk);
        delay_req = (AW+1)'(r);
        set_delay = 1'b1;
        @(negedge clk);
        set_delay = 1'b0;
        repeat (4) @(negedge clk);
        cur_d = model_clamp(r);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(out_sample == '0, "R1 out_sample", out_sample, '0);
        check(!out_strobe, "R1 out_strobe", {15'd0, out_strobe}, '0);

        // R3 / R7: default delay, zero until filled
        for (int i = 0; i < 20; i++) begin
            send_tick(DW'($urandom), (n_ticks < INITD) ? "R7 fill" : "R3 default");
        end

        // R4: shorter delay
        request_delay(3);
        for (int i = 0; i < 10; i++) send_tick(DW'($urandom), "R4 delay3");

        // R6: zero request means one sample
        request_delay(0);
        for (int i = 0; i < 5; i++) send_tick(DW'($urandom), "R6 zero_req");

        // R5 / R7: oversized request clamps, zeros until enough stored
        request_delay(100);
        for (int i = 0; i < 40; i++) begin
            send_tick(DW'($urandom), (n_ticks < DEPTH - 1) ? "R7 refill" : "R5 clamp");
        end

        // R9: back-to-back strobes
        request_delay(5);
        for (int i = 0; i < 4; i++) send_pair(DW'($urandom), DW'($urandom));

        // R8: long random run past several wraps
        for (int i = 0; i < 150; i++) begin
            if (($urandom % 10) == 0) request_delay(int'($urandom % 128));
            send_tick(DW'($urandom), "R8 wrap");
        end

        // directed corner: ones pattern at maximum delay after wrap
        request_delay(DEPTH - 1);
        for (int i = 0; i < 4; i++) send_tick(16'hFFFF, "R5 max_after_wrap");

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule